// File: doc/BRIEF.md
# Inter-Processor Message Target Selector

This block sits beside a group of local interrupt units and decides, for every inter-processor message, which of those units are addressed by it. Each unit owns an 8-bit physical ID, an 8-bit logical ID and a destination-format register. The block decodes the message's two command words (shorthand, destination mode, destination field and delivery mode), runs one matcher per unit, and presents the resulting match bitmap one clock after the message is offered.

When the delivery mode asks for lowest-priority delivery, a round-robin arbiter chooses exactly one target among the matching units that are also enabled. It remembers the last winner and starts the next search at the following index, wrapping around. If no unit qualifies it raises a no-target flag instead of a grant. Moving the message and performing the delivery are left to the surrounding logic.

Top module: `ipi_dest_fabric`

## Requirements
- R1: Shorthand is command-low bits [19:18]: 00 uses the destination field; 01 matches only the sending unit (index `sender_idx`); 10 matches every unit; 11 matches every unit except the sender.
- R2: With shorthand 00 and command-low bit 11 equal to 0 (physical), a unit matches when command-high bits [31:24] equal its ID or equal 0xFF.
- R3: With shorthand 00 and bit 11 equal to 1 (logical), a unit whose format register bits [31:28] are 1111 (flat) matches when its logical ID ANDed with the destination is nonzero.
- R4: In logical mode a unit whose format bits [31:28] are 0000 (cluster) matches when the upper nibbles of logical ID and destination are equal and the AND of their lower nibbles is nonzero.
- R5: In logical mode a unit whose format bits [31:28] are any value other than 1111 or 0000 never matches.
- R6: Each format register resets to 0xFFFFFFFF; a write stores the written word ORed with 0x0FFFFFFF, so only bits [31:28] change. All registers are read on `fmt_q`, unit u at bits [u*32 +: 32].
- R7: `res_valid` and `match_map` (bit u for unit u) appear on the clock edge after `msg_valid` is sampled; with `res_valid` low, `grant_valid` and `no_target` are low.
- R8: Delivery mode command-low bits [10:8] = 001 is lowest priority: the grant goes to the first unit that both matches and has `unit_en` set, searching from the index after the last winner upward with wrap; that unit becomes the last winner. After reset the last winner is the highest index, so the first search starts at unit 0.
- R9: A lowest-priority message with no matching enabled unit gives `grant_valid` low and `no_target` high and leaves the last winner unchanged.
- R10: Any other delivery mode gives `grant_valid` and `no_target` low and leaves the last winner unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_valid | input | 1 | A message is offered this cycle |
| cmd_lo | input | 32 | Low command word (shorthand, mode, delivery mode) |
| cmd_hi | input | 32 | High command word, destination in [31:24] |
| sender_idx | input | IDX_W | Index of the unit sending the message |
| unit_id | input | NUM_UNITS*8 | Physical IDs, unit u at [u*8 +: 8] |
| unit_ldr | input | NUM_UNITS*8 | Logical IDs, unit u at [u*8 +: 8] |
| unit_en | input | NUM_UNITS | Unit may accept lowest-priority delivery |
| fmt_wr_en | input | NUM_UNITS | Write strobe for each unit's format register |
| fmt_wr_data | input | 32 | Data word for format register writes |
| fmt_q | output | NUM_UNITS*32 | Format register contents |
| res_valid | output | 1 | Result for the previous-cycle message |
| match_map | output | NUM_UNITS | Per-unit match bits |
| grant_valid | output | 1 | Lowest-priority winner is valid |
| grant_idx | output | IDX_W | Lowest-priority winner index |
| no_target | output | 1 | Lowest-priority message found no eligible unit |

## Verification
The assertions assume the command words, `sender_idx`, the IDs and `unit_en` are stable across the edge where `msg_valid` is sampled, and that `sender_idx` is below the unit count. They also assume format writes are not issued in the same cycle as a logical message whose result is checked against the new format. The stimulus changes configuration only while `msg_valid` is low, drives every message field at the falling edge, and always picks a sender index inside the unit range.

// File: rtl/ipi_dest_pkg.sv
package ipi_dest_pkg;

  localparam int ID_W = 8;

  typedef enum logic [1:0] {
    SH_NONE   = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shorthand_e;

  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;
  localparam logic [2:0] DM_LOWPRI   = 3'b001;
  localparam logic [31:0] FMT_FIXED_ONES = 32'h0FFF_FFFF;

  typedef struct packed {
    shorthand_e      sh;
    logic            logical;
    logic [2:0]      dmode;
    logic [ID_W-1:0] dest;
  } ipi_cmd_t;

  function automatic ipi_cmd_t decode_cmd(input logic [31:0] lo, input logic [31:0] hi);
    ipi_cmd_t c;
    c.sh      = shorthand_e'(lo[19:18]);
    c.logical = lo[11];
    c.dmode   = lo[10:8];
    c.dest    = hi[31:24];
    return c;
  endfunction

  function automatic logic phys_hit(input logic [ID_W-1:0] dest, input logic [ID_W-1:0] id);
    return (dest == {ID_W{1'b1}}) || (dest == id);
  endfunction

  function automatic logic logical_hit(input logic [ID_W-1:0] dest,
                                       input logic [ID_W-1:0] lid,
                                       input logic [3:0] fmt);
    logic r;
    case (fmt)
      FMT_FLAT:    r = |(lid & dest);
      FMT_CLUSTER: r = (lid[7:4] == dest[7:4]) && (|(lid[3:0] & dest[3:0]));
      default:     r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ipi_fmt_reg.sv
module ipi_fmt_reg
  import ipi_dest_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] fmt_word,
  output logic [3:0]  fmt_mode
);

  logic [3:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= 4'hF;
    else if (wr_en) mode_q <= wr_data[31:28];
  end

  assign fmt_mode = mode_q;
  assign fmt_word = {mode_q, 28'd0} | FMT_FIXED_ONES;

  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (fmt_word == ($past(wr_data) | 32'h0FFF_FFFF)));

endmodule

// File: rtl/ipi_dest_unit.sv
module ipi_dest_unit
  import ipi_dest_pkg::*;
(
  input  ipi_cmd_t        cmd,
  input  logic            is_sender,
  input  logic [ID_W-1:0] my_id,
  input  logic [ID_W-1:0] my_lid,
  input  logic [3:0]      fmt_mode,
  output logic            hit
);

  logic addr_hit;
  logic phys_w;
  logic logi_w;

  assign phys_w   = phys_hit(cmd.dest, my_id);
  assign logi_w   = logical_hit(cmd.dest, my_lid, fmt_mode);
  assign addr_hit = cmd.logical ? logi_w : phys_w;

  always_comb begin
    case (cmd.sh)
      SH_NONE:   hit = addr_hit;
      SH_SELF:   hit = is_sender;
      SH_ALL:    hit = 1'b1;
      SH_OTHERS: hit = !is_sender;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/ipi_rr_arbiter.sv
module ipi_rr_arbiter #(
  parameter int NUM_UNITS = 8,
  localparam int IDX_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic [NUM_UNITS-1:0] cand,
  output logic                 grant_vld,
  output logic [IDX_W-1:0]     grant_idx,
  output logic                 none
);

  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] pick;
  logic             found;
  logic             grant_q;
  logic             none_q;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NUM_UNITS; k++) begin
      int t;
      t = (int'(last_q) + k) % NUM_UNITS;
      if (!found && cand[t]) begin
        found = 1'b1;
        pick  = IDX_W'(t);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= IDX_W'(NUM_UNITS - 1);
      grant_q <= 1'b0;
      none_q  <= 1'b0;
      idx_q   <= '0;
    end else if (req) begin
      grant_q <= found;
      none_q  <= !found;
      if (found) begin
        idx_q  <= pick;
        last_q <= pick;
      end
    end else begin
      grant_q <= 1'b0;
      none_q  <= 1'b0;
    end
  end

  assign grant_vld = grant_q;
  assign grant_idx = idx_q;
  assign none      = none_q;

  a_r9_ptr_hold_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !found) |=> $stable(last_q));

  a_r10_ptr_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(last_q));

  a_r9_grant_none_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_vld && none));

endmodule

// File: rtl/ipi_dest_fabric.sv
module ipi_dest_fabric
  import ipi_dest_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  localparam int IDX_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      msg_valid,
  input  logic [31:0]               cmd_lo,
  input  logic [31:0]               cmd_hi,
  input  logic [IDX_W-1:0]          sender_idx,
  input  logic [NUM_UNITS*ID_W-1:0] unit_id,
  input  logic [NUM_UNITS*ID_W-1:0] unit_ldr,
  input  logic [NUM_UNITS-1:0]      unit_en,
  input  logic [NUM_UNITS-1:0]      fmt_wr_en,
  input  logic [31:0]               fmt_wr_data,
  output logic [NUM_UNITS*32-1:0]   fmt_q,
  output logic                      res_valid,
  output logic [NUM_UNITS-1:0]      match_map,
  output logic                      grant_valid,
  output logic [IDX_W-1:0]          grant_idx,
  output logic                      no_target
);

  ipi_cmd_t             cmd;
  logic [NUM_UNITS-1:0] hit_now;
  logic [NUM_UNITS-1:0] lp_cand;
  logic                 lp_req;
  logic                 res_q;
  logic [NUM_UNITS-1:0] map_q;

  assign cmd     = decode_cmd(cmd_lo, cmd_hi);
  assign lp_req  = msg_valid && (cmd.dmode == DM_LOWPRI);
  assign lp_cand = hit_now & unit_en;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [3:0] mode_w;

    ipi_fmt_reg fmt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (fmt_wr_en[u]),
      .wr_data  (fmt_wr_data),
      .fmt_word (fmt_q[u*32 +: 32]),
      .fmt_mode (mode_w)
    );

    ipi_dest_unit match_i (
      .cmd       (cmd),
      .is_sender (sender_idx == IDX_W'(u)),
      .my_id     (unit_id[u*ID_W +: ID_W]),
      .my_lid    (unit_ldr[u*ID_W +: ID_W]),
      .fmt_mode  (mode_w),
      .hit       (hit_now[u])
    );
  end

  ipi_rr_arbiter #(.NUM_UNITS(NUM_UNITS)) arb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (lp_req),
    .cand      (lp_cand),
    .grant_vld (grant_valid),
    .grant_idx (grant_idx),
    .none      (no_target)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= 1'b0;
      map_q <= '0;
    end else begin
      res_q <= msg_valid;
      if (msg_valid) map_q <= hit_now;
    end
  end

  assign res_valid = res_q;
  assign match_map = map_q;

  a_r1_self_only_sender: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && cmd_lo[19:18] == 2'b01) |=>
      (match_map == (NUM_UNITS'(1) << $past(sender_idx))));

  a_r1_all_including: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && cmd_lo[19:18] == 2'b10) |=> (&match_map));

  a_r1_all_excluding: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && cmd_lo[19:18] == 2'b11) |=>
      (match_map == ~(NUM_UNITS'(1) << $past(sender_idx))));

  a_r2_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && cmd_lo[19:18] == 2'b00 && !cmd_lo[11] && cmd_hi[31:24] == 8'hFF)
      |=> (&match_map));

  a_r7_quiet_without_result: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!grant_valid && !no_target));

  a_r8_grant_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && grant_valid) |-> match_map[grant_idx]);

  a_r10_no_grant_other_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && cmd_lo[10:8] != 3'b001) |=> (!grant_valid && !no_target));

endmodule

// File: tb/ipi_dest_fabric_tb.sv
`timescale 1ns/1ps
module ipi_dest_fabric_tb_top;

  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          msg_valid = 1'b0;
  logic [31:0]   cmd_lo = '0;
  logic [31:0]   cmd_hi = '0;
  logic [IW-1:0] sender_idx = '0;
  logic [N*8-1:0] unit_id = '0;
  logic [N*8-1:0] unit_ldr = '0;
  logic [N-1:0]  unit_en = '0;
  logic [N-1:0]  fmt_wr_en = '0;
  logic [31:0]   fmt_wr_data = '0;
  logic [N*32-1:0] fmt_q;
  logic          res_valid;
  logic [N-1:0]  match_map;
  logic          grant_valid;
  logic [IW-1:0] grant_idx;
  logic          no_target;

  ipi_dest_fabric #(.NUM_UNITS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
    .sender_idx(sender_idx), .unit_id(unit_id), .unit_ldr(unit_ldr), .unit_en(unit_en),
    .fmt_wr_en(fmt_wr_en), .fmt_wr_data(fmt_wr_data), .fmt_q(fmt_q), .res_valid(res_valid),
    .match_map(match_map), .grant_valid(grant_valid), .grant_idx(grant_idx),
    .no_target(no_target)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] fmt_m [N];
  int          rr_last;

  logic [N-1:0] q_map [$];
  logic         q_gv  [$];
  logic [IW-1:0] q_gi [$];
  logic         q_nt  [$];
  string        q_tag [$];

  task automatic check(input bit ok, input string tag, input logic [N*32-1:0] act,
                       input logic [N*32-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit model_hit(int u, logic [31:0] lo, logic [31:0] hi, int snd);
    logic [7:0] d, lid;
    d   = hi[31:24];
    lid = unit_ldr[u*8 +: 8];
    if (lo[19:18] == 2'b01) return u == snd;
    if (lo[19:18] == 2'b10) return 1;
    if (lo[19:18] == 2'b11) return u != snd;
    if (lo[11] == 1'b0) return (d == 8'hFF) || (d == unit_id[u*8 +: 8]);
    if (fmt_m[u][31:28] == 4'b1111) return (lid & d) != 8'h00;
    if (fmt_m[u][31:28] == 4'b0000)
      return (lid[7:4] == d[7:4]) && ((lid[3:0] & d[3:0]) != 4'h0);
    return 0;
  endfunction

  task automatic send(input logic [31:0] lo, input logic [31:0] hi, input int snd,
                      input string tag);
    logic [N-1:0] m;
    bit gv, nt;
    int gi;
    @(negedge clk);
    msg_valid  = 1'b1;
    cmd_lo     = lo;
    cmd_hi     = hi;
    sender_idx = IW'(snd);
    for (int u = 0; u < N; u++) m[u] = model_hit(u, lo, hi, snd);
    gv = 0; nt = 0; gi = 0;
    if (lo[10:8] == 3'b001) begin
      for (int k = 1; k <= N; k++) begin
        int t;
        t = (rr_last + k) % N;
        if (!gv && m[t] && unit_en[t]) begin gv = 1; gi = t; end
      end
      nt = !gv;
      if (gv) rr_last = gi;
    end
    q_map.push_back(m);
    q_gv.push_back(gv);
    q_gi.push_back(IW'(gi));
    q_nt.push_back(nt);
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic write_fmt(input logic [N-1:0] mask, input logic [31:0] data);
    logic [N*32-1:0] e;
    @(negedge clk);
    fmt_wr_en   = mask;
    fmt_wr_data = data;
    for (int u = 0; u < N; u++) if (mask[u]) fmt_m[u] = data | 32'h0FFF_FFFF;
    @(negedge clk);
    fmt_wr_en = '0;
    for (int u = 0; u < N; u++) e[u*32 +: 32] = fmt_m[u];
    check(fmt_q == e, "R6 format write", fmt_q, e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (q_map.size() == 0) begin
        check(0, "R7 unexpected result", 1, 0);
      end else begin
        logic [N-1:0] m; logic gv, nt; logic [IW-1:0] gi; string tg;
        m = q_map.pop_front(); gv = q_gv.pop_front(); gi = q_gi.pop_front();
        nt = q_nt.pop_front(); tg = q_tag.pop_front();
        check(match_map == m, {tg, " match_map"}, match_map, m);
        check(grant_valid == gv && no_target == nt, {tg, " grant/no_target"},
              {grant_valid, no_target}, {gv, nt});
        if (gv) check(grant_idx == gi, {tg, " grant_idx"}, grant_idx, gi);
      end
    end else if (rst_n) begin
      if (grant_valid || no_target) check(0, "R7 flags without result",
                                          {grant_valid, no_target}, 0);
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N*32-1:0] e;
    for (int u = 0; u < N; u++) begin
      unit_id[u*8 +: 8]  = 8'h20 + 8'(u);
      unit_ldr[u*8 +: 8] = 8'(1 << u);
      fmt_m[u] = 32'hFFFF_FFFF;
    end
    rr_last = N - 1;
    unit_en = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    e = '1;
    check(fmt_q == e, "R6 reset value", fmt_q, e);
    check(!res_valid && !grant_valid && !no_target && match_map == '0, "R7 reset outputs",
          {res_valid, grant_valid, no_target, match_map}, 0);

    // R2 physical
    send(32'h0000_0000, 32'h2300_0000, 0, "R2 phys id");
    send(32'h0000_0000, 32'hFF00_0000, 1, "R2 phys broadcast");
    send(32'h0000_0000, 32'h9900_0000, 2, "R2 phys miss");
    // R1 shorthands
    send(32'h0004_0000, 32'h2000_0000, 5, "R1 self");
    send(32'h0008_0000, 32'h0000_0000, 3, "R1 all incl");
    send(32'h000C_0000, 32'h2200_0000, 2, "R1 all excl");
    // R3 flat
    send(32'h0000_0800, 32'h8100_0000, 0, "R3 flat");
    send(32'h0000_0800, 32'h0000_0000, 0, "R3 flat zero dest");
    idle();

    // R4 cluster on units 0..3
    write_fmt(8'h0F, 32'h0000_0000);
    unit_ldr[0*8 +: 8] = 8'h31;
    unit_ldr[1*8 +: 8] = 8'h32;
    unit_ldr[2*8 +: 8] = 8'h41;
    unit_ldr[3*8 +: 8] = 8'h42;
    send(32'h0000_0800, 32'h3300_0000, 0, "R4 cluster");
    send(32'h0000_0800, 32'h4200_0000, 0, "R4 cluster other");
    send(32'h0000_0800, 32'h3400_0000, 0, "R4 cluster nibble miss");
    idle();

    // R5 bad format on unit 6, otherwise flat
    write_fmt(8'h40, 32'h5123_4567);
    send(32'h0000_0800, 32'hFF00_0000, 0, "R5 bad format");
    idle();

    // R8 lowest priority rotation
    unit_en = 8'b1010_0110;
    send(32'h0000_0100, 32'hFF00_0000, 0, "R8 lowpri first");
    send(32'h0000_0100, 32'hFF00_0000, 0, "R8 lowpri second");
    send(32'h0000_0100, 32'hFF00_0000, 0, "R8 lowpri third");
    send(32'h0000_0100, 32'hFF00_0000, 0, "R8 lowpri fourth");
    send(32'h0000_0100, 32'hFF00_0000, 0, "R8 lowpri wrap");
    send(32'h0000_0100, 32'h2000_0000, 0, "R9 lowpri disabled target");
    send(32'h0000_0100, 32'h2500_0000, 0, "R8 lowpri after miss");
    send(32'h0000_0000, 32'hFF00_0000, 0, "R10 fixed mode");
    send(32'h0000_0200, 32'hFF00_0000, 0, "R10 other mode");
    send(32'h0000_0100, 32'hFF00_0000, 0, "R10 pointer kept");
    idle();
    unit_en = '0;
    send(32'h0008_0100, 32'h0000_0000, 0, "R9 none enabled");
    idle();
    unit_en = '1;
    send(32'h000C_0100, 32'h0000_0000, 7, "R8 lowpri excl sender");
    idle();
    repeat (3) @(negedge clk);
    check(q_map.size() == 0, "R7 all results seen", q_map.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule